// File: doc/BRIEF.md
# Line-Crossing Access Splitter

This block sits between a load/store pipeline and a memory port. It takes a single access of 1, 2, 4 or 8 bytes at any byte address. It then decides whether the bytes of that access fall into one cache line or run over into the next one. An access that stays inside one line is passed on as a single sub-request. An access that crosses a line is cut into two sub-requests. Each sub-request lies wholly inside one line and carries its own address and byte count.

The two pieces go out one after the other on a valid/ready memory port. The second piece is offered only once the port has accepted the first. Responses come back in issue order, one per sub-request. A response counter collects them, and load bytes are merged little-endian into an 8-byte buffer. Once every piece has answered, the block raises one completion. That completion carries the original address, size and direction. Store data is handed out in the same way: the second piece sends the bytes that follow the first piece's byte count.

Top module: `line_split_unit`

## Requirements
- R1: After reset, req_ready is 1, mem_valid is 0 and done_valid is 0.
- R2: req_size encodes the byte count N as 0=1, 1=2, 2=4, 3=8. The block computes B = (req_addr + N - 1) rounded down to a multiple of LINE_BYTES. When B is not greater than req_addr, exactly one sub-request is issued, with mem_addr = req_addr and mem_bytes = N. No sub-request ever spans two lines.
- R3: When B > req_addr, the first sub-request has mem_addr = req_addr and mem_bytes = B - req_addr.
- R4: When B > req_addr, the second sub-request has mem_addr = B and mem_bytes = req_addr + N - B. It is presented only in a cycle after the first one was accepted.
- R5: While mem_valid is 1 and mem_ready is 0, mem_valid, mem_addr, mem_bytes and mem_write hold their values into the next cycle.
- R6: For stores, the low mem_bytes bytes of mem_wdata are request data bytes 0 onward for the first piece. For the second piece they are request data bytes starting at the first piece's byte count.
- R7: For loads, the low bytes of each response are placed in done_rdata at the piece's offset: 0 for the first piece, and the first piece's byte count for the second. Byte i of done_rdata is memory byte req_addr+i. Response bytes above the piece's size are ignored, and done_rdata bytes at or above N are 0.
- R8: done_valid is high for exactly one cycle, namely the cycle after the final response is taken. It is never high while a piece is still outstanding. It carries the original address, size and write flag, and for stores done_rdata is 0.
- R9: req_ready is 1 only when no access is in flight. It returns to 1 in the cycle after done_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle, request taken on valid and ready |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Size code, byte count 1 << req_size |
| req_wdata | input | 64 | Store data, byte 0 at the access address |
| mem_valid | output | 1 | Sub-request present |
| mem_ready | input | 1 | Memory port accepts the sub-request |
| mem_write | output | 1 | Sub-request direction |
| mem_addr | output | ADDR_W | Sub-request byte address |
| mem_bytes | output | 4 | Sub-request byte count, 1 to 8 |
| mem_wdata | output | 64 | Sub-request store data in the low bytes |
| rsp_valid | input | 1 | One sub-request response, in issue order |
| rsp_rdata | input | 64 | Response load data in the low bytes |
| done_valid | output | 1 | Merged completion, one cycle |
| done_write | output | 1 | Direction of the completed access |
| done_addr | output | ADDR_W | Original access address |
| done_size | output | 2 | Original size code |
| done_rdata | output | 64 | Merged load data, little-endian |

## Verification
The piece boundary is worked out once, at accept. A wrong boundary therefore shows up on the very first sub-request, as a wrong mem_bytes or a piece that runs past a line end. A wrong response counter shows up within one cycle of the last response, as a completion that comes too early, too late or not at all. That in turn holds req_ready low and stalls the next request. A wrong merge offset or mask shows up only at completion, as misplaced bytes in done_rdata. Forcing the response's unused upper bytes to a non-zero pattern makes a missing mask visible.

// File: rtl/line_split_unit.sv
module line_split_unit #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_bytes,
  output logic [63:0]       mem_wdata,
  input  logic              rsp_valid,
  input  logic [63:0]       rsp_rdata,
  output logic              done_valid,
  output logic              done_write,
  output logic [ADDR_W-1:0] done_addr,
  output logic [1:0]        done_size,
  output logic [63:0]       done_rdata
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'(LINE_BYTES - 1));

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_DONE} state_t;
  state_t state_q;

  logic [ADDR_W-1:0] a_q;
  logic [1:0]        sz_q;
  logic [3:0]        n_q, first_q;
  logic              wr_q, split_q, issued_q;
  logic [1:0]        rcvd_q;
  logic [63:0]       wd_q, buf_q;

  logic [3:0]        nbytes, first_n, rsp_n, rsp_off;
  logic [ADDR_W-1:0] end_a, sec_a;
  logic              crosses, last_rsp;
  logic [63:0]       rsp_mask;

  assign nbytes  = 4'd1 << req_size;
  assign end_a   = req_addr + ADDR_W'(nbytes) - ADDR_W'(1);
  assign sec_a   = end_a & LINE_MASK;
  assign crosses = sec_a > req_addr;
  assign first_n = crosses ? 4'(sec_a - req_addr) : nbytes;

  assign rsp_off  = rcvd_q[0] ? first_q : 4'd0;
  assign rsp_n    = rcvd_q[0] ? (n_q - first_q) : first_q;
  assign rsp_mask = (64'd1 << {rsp_n, 3'b000}) - 64'd1;
  assign last_rsp = rsp_valid && (rcvd_q + 2'd1 == (split_q ? 2'd2 : 2'd1));

  assign req_ready  = state_q == S_IDLE;
  assign mem_valid  = state_q == S_SEND;
  assign mem_write  = wr_q;
  assign mem_addr   = issued_q ? a_q + ADDR_W'(first_q) : a_q;
  assign mem_bytes  = issued_q ? n_q - first_q : first_q;
  assign mem_wdata  = issued_q ? wd_q >> {first_q, 3'b000} : wd_q;

  assign done_valid = state_q == S_DONE;
  assign done_write = wr_q;
  assign done_addr  = a_q;
  assign done_size  = sz_q;
  assign done_rdata = buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      a_q      <= '0;
      sz_q     <= '0;
      n_q      <= '0;
      first_q  <= '0;
      wr_q     <= 1'b0;
      split_q  <= 1'b0;
      issued_q <= 1'b0;
      rcvd_q   <= '0;
      wd_q     <= '0;
      buf_q    <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid) begin
          a_q      <= req_addr;
          sz_q     <= req_size;
          n_q      <= nbytes;
          first_q  <= first_n;
          wr_q     <= req_write;
          split_q  <= crosses;
          wd_q     <= req_wdata;
          issued_q <= 1'b0;
          rcvd_q   <= '0;
          buf_q    <= '0;
          state_q  <= S_SEND;
        end
        S_SEND: if (mem_ready) begin
          if (split_q && !issued_q) issued_q <= 1'b1;
          else                      state_q  <= S_WAIT;
        end
        S_WAIT: if (last_rsp) state_q <= S_DONE;
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
      if (rsp_valid && (state_q == S_SEND || state_q == S_WAIT)) begin
        rcvd_q <= rcvd_q + 2'd1;
        if (!wr_q) buf_q <= buf_q | ((rsp_rdata & rsp_mask) << {rsp_off, 3'b000});
      end
    end
  end
endmodule

// File: rtl/line_split_unit_chk.sv
module line_split_unit_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_bytes,
  input logic              done_valid
);
  localparam logic [ADDR_W-1:0] LMASK = ~(ADDR_W'(LINE_BYTES - 1));

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (req_ready && !mem_valid && !done_valid));

  p_one_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ((mem_addr & LMASK) ==
                   ((mem_addr + ADDR_W'(mem_bytes) - ADDR_W'(1)) & LMASK)));

  p_bytes_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_bytes >= 4'd1 && mem_bytes <= 4'd8));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_bytes) && $stable(mem_write)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && req_ready));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_valid && !done_valid));
endmodule

bind line_split_unit line_split_unit_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
  .mem_bytes(mem_bytes), .done_valid(done_valid)
);

// File: tb/line_split_unit_tb_top.sv
`timescale 1ns/1ps
module line_split_unit_tb_top;
  localparam int AW = 32;
  localparam int LB = 64;
  localparam int NREQ = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [63:0] req_wdata = '0;
  logic mem_ready = 1'b0, rsp_valid = 1'b0;
  logic [63:0] rsp_rdata = '0;
  logic req_ready, mem_valid, mem_write, done_valid, done_write;
  logic [AW-1:0] mem_addr, done_addr;
  logic [3:0] mem_bytes;
  logic [63:0] mem_wdata, done_rdata;
  logic [1:0] done_size;

  always #2.5 clk = ~clk;

  line_split_unit #(.ADDR_W(AW), .LINE_BYTES(LB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_bytes(mem_bytes),
    .mem_wdata(mem_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .done_valid(done_valid), .done_write(done_write), .done_addr(done_addr),
    .done_size(done_size), .done_rdata(done_rdata));

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
    return 8'((a * 13) ^ (a >> 8) ^ 32'h5A);
  endfunction

  function automatic logic [63:0] bmask(input int n);
    return (n >= 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * n)) - 64'd1);
  endfunction

  // expected sub-requests
  logic [AW-1:0] ex_a[$];
  int            ex_n[$];
  logic [63:0]   ex_d[$];
  // pending responses
  int            rq_t[$];
  logic [63:0]   rq_d[$];

  bit busy = 0, done_due = 0, cur_w = 0, drop_req = 0;
  logic [AW-1:0] cur_a;
  logic [1:0] cur_s;
  logic [63:0] cur_rd;
  int rsp_left = 0, last_t = 0, cyc = 0, next_i = 0;

  logic [AW-1:0] d_addr [16];
  logic [1:0]    d_size [16];

  task automatic accept();
    int n;
    logic [AW-1:0] b;
    n = 1 << req_size;
    b = (req_addr + AW'(n) - 1) & ~(AW'(LB - 1));
    busy = 1; cur_a = req_addr; cur_s = req_size; cur_w = req_write; cur_rd = '0;
    for (int i = 0; i < n; i++) if (!req_write) cur_rd[8*i +: 8] = mbyte(req_addr + AW'(i));
    if (b > req_addr) begin
      int f;
      f = int'(b - req_addr);
      ex_a.push_back(req_addr); ex_n.push_back(f); ex_d.push_back(req_wdata);
      ex_a.push_back(b); ex_n.push_back(n - f); ex_d.push_back(req_wdata >> (8 * f));
      rsp_left = 2;
    end else begin
      ex_a.push_back(req_addr); ex_n.push_back(n); ex_d.push_back(req_wdata);
      rsp_left = 1;
    end
  endtask

  initial begin
    d_addr = '{32'h100, 32'h13D, 32'h13F, 32'h13F, 32'h139, 32'h138, 32'h13C, 32'h13E,
               32'h100, 32'h13D, 32'h13F, 32'h13F, 32'h139, 32'h138, 32'h13C, 32'h13E};
    d_size = '{2'd3, 2'd2, 2'd1, 2'd0, 2'd3, 2'd3, 2'd2, 2'd2,
               2'd3, 2'd2, 2'd1, 2'd0, 2'd3, 2'd3, 2'd2, 2'd2};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready === 1'b1, "R1 req_ready after reset", 64'(req_ready), 64'd1);
    chk(mem_valid === 1'b0, "R1 mem_valid after reset", 64'(mem_valid), 64'd0);
    chk(done_valid === 1'b0, "R1 done_valid after reset", 64'(done_valid), 64'd0);
    while (next_i < NREQ || busy || req_valid) begin
      @(negedge clk);
      if (cyc > 100000) begin
        chk(1'b0, "watchdog expired", 64'(cyc), 64'd100000);
        break;
      end
      // drive
      if (drop_req) begin req_valid = 1'b0; drop_req = 0; end
      else if (!req_valid && next_i < NREQ) begin
        req_valid = 1'b1;
        if (next_i < 16) begin
          req_addr = d_addr[next_i]; req_size = d_size[next_i]; req_write = next_i >= 8;
        end else begin
          req_addr = AW'($urandom % 4096); req_size = 2'($urandom % 4); req_write = 1'($urandom % 2);
        end
        req_wdata = {$urandom, $urandom};
        next_i++;
      end
      mem_ready = ($urandom % 4) != 0;
      if (rq_t.size() > 0 && rq_t[0] <= cyc) begin
        rsp_valid = 1'b1; rsp_rdata = rq_d[0];
      end else begin
        rsp_valid = 1'b0; rsp_rdata = 64'hEEEE_EEEE_EEEE_EEEE;
      end
      #1;
      // compare
      chk(req_ready === !busy, "R9 req_ready", 64'(req_ready), 64'(!busy));
      chk(done_valid === done_due, "R8 done_valid timing", 64'(done_valid), 64'(done_due));
      if (done_valid && done_due) begin
        chk(done_addr === cur_a, "R8 done_addr", 64'(done_addr), 64'(cur_a));
        chk(done_size === cur_s, "R8 done_size", 64'(done_size), 64'(cur_s));
        chk(done_write === cur_w, "R8 done_write", 64'(done_write), 64'(cur_w));
        chk(done_rdata === cur_rd, "R7 done_rdata merge", done_rdata, cur_rd);
      end
      chk(mem_valid === (busy && ex_a.size() > 0), "R4 mem_valid",
          64'(mem_valid), 64'(busy && ex_a.size() > 0));
      if (mem_valid && ex_a.size() > 0) begin
        chk(mem_addr === ex_a[0], "R3 mem_addr", 64'(mem_addr), 64'(ex_a[0]));
        chk(int'(mem_bytes) == ex_n[0], "R2 mem_bytes", 64'(mem_bytes), 64'(ex_n[0]));
        chk(mem_write === cur_w, "R2 mem_write", 64'(mem_write), 64'(cur_w));
        if (cur_w)
          chk((mem_wdata & bmask(ex_n[0])) === (ex_d[0] & bmask(ex_n[0])), "R6 mem_wdata",
              mem_wdata & bmask(ex_n[0]), ex_d[0] & bmask(ex_n[0]));
      end
      // advance reference across the coming edge
      if (done_due) begin done_due = 0; busy = 0; end
      if (req_valid && req_ready) begin accept(); drop_req = 1; end
      if (mem_valid && mem_ready && ex_a.size() > 0) begin
        logic [63:0] d;
        int t;
        d = 64'hEEEE_EEEE_EEEE_EEEE;
        for (int i = 0; i < ex_n[0]; i++) d[8*i +: 8] = mbyte(ex_a[0] + AW'(i));
        t = cyc + 1 + int'($urandom % 3);
        if (t <= last_t) t = last_t + 1;
        last_t = t;
        rq_t.push_back(t); rq_d.push_back(d);
        void'(ex_a.pop_front()); void'(ex_n.pop_front()); void'(ex_d.pop_front());
      end
      if (rsp_valid) begin
        void'(rq_t.pop_front()); void'(rq_d.pop_front());
        rsp_left--;
        if (rsp_left == 0) done_due = 1;
      end
      cyc++;
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule